// File: doc/BRIEF.md
# Dual-Mode Asynchronous Host Register Port

This block sits between an external microprocessor bus and a small bank of internal configuration registers. A static strap `bus_moto` picks the bus style. With the strap low, the bus uses a separate active-high address latch enable and separate active-low read and write strobes. With the strap high, the bus uses an active-low address strobe, an active-low data strobe and a read/not-write line. In both styles an active-low chip select must be asserted before any access takes effect. Every host pin passes through a two-flop synchronizer into the block clock domain before any decoding.

A second strap, `mode_host`, picks between host mode and hardware mode. In host mode the pins carry register traffic. In hardware mode the register port is held idle. The strobe pin then becomes a send-all-ones command for line channel 2, and the select pin becomes the same command for channel 3. The pins are treated as weakly pulled low, so an unconnected pin reads as 0 and leaves both commands off.

The access controller is a six-state machine:
- `ST_IDLE`: no cycle in progress.
- `ST_LATCH`: address latch enable is high and the address is being followed.
- `ST_ARMED`: the address is held and the machine waits for a data strobe.
- `ST_WRITE`: a single-cycle commit.
- `ST_DRAIN`: the machine waits for the write strobe to be released.
- `ST_READ`: the read data is driven.

The transitions are:
- IDLE→LATCH: latch enable rises (latch-enable style).
- IDLE→ARMED: address strobe and select are both low (strobe style).
- LATCH→ARMED: latch enable falls.
- ARMED→LATCH: latch enable rises again (latch-enable style).
- ARMED→WRITE or ARMED→READ: a qualified strobe arrives.
- ARMED→IDLE: address strobe or select is released (strobe style).
- WRITE→DRAIN: always, after one cycle.
- DRAIN→ARMED and READ→ARMED: the data strobe is released while the address strobe is still held (strobe style).
- DRAIN→IDLE and READ→IDLE: the cycle ends.
- Any state→IDLE: hardware mode is selected.

Top module: `dualbus_regport`

## Requirements
- R1: After reset, `rdata` is 0, `rdata_oe` is 0, both channel commands are 0, and every register reads back as 0.
- R2: With `bus_moto`=0, the address follows `addr` while `ale_as` is high and is held from its falling edge. A low `wr_rw` (write strobe) with `cs_n` low writes `wdata`. A low `rd_ds_n` (read strobe) with `cs_n` low reads.
- R3: With `bus_moto`=1, the address is captured when `ale_as` and `cs_n` are both low. A low `rd_ds_n` (data strobe) then performs a read when `wr_rw`=1 and a write when `wr_rw`=0.
- R4: With `bus_moto`=1, reads and writes complete correctly when `ale_as` and `cs_n` fall in the same cycle.
- R5: Strobes given while `cs_n` is high change no register.
- R6: A write strobe, however long it is held, commits the data exactly once.
- R7: While a read strobe and `cs_n` stay asserted, `rdata_oe` is 1 and `rdata` stays constant. Within 6 cycles of release, `rdata_oe` is 0 and `rdata` is 0.
- R8: Register addresses 16 and above read back as 0, and writes to them are dropped.
- R9: With `mode_host`=0, `taos_ch2` follows `ale_as` and `taos_ch3` follows `cs_n` (1 = send all ones) after the synchronizer delay. No register access occurs.
- R10: With `mode_host`=1, `taos_ch2` and `taos_ch3` stay 0 whatever the pins do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_host | input | 1 | Strap: 1 = host register mode, 0 = hardware command mode |
| bus_moto | input | 1 | Strap: 0 = latch-enable style, 1 = address-strobe style |
| ale_as | input | 1 | Latch enable (high) / address strobe (low) / channel 2 command |
| cs_n | input | 1 | Chip select, active low / channel 3 command |
| rd_ds_n | input | 1 | Read strobe or data strobe, active low |
| wr_rw | input | 1 | Write strobe (active low) or read/not-write line |
| addr | input | 7 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, 0 when not driving |
| rdata_oe | output | 1 | Read data valid / bus drive enable |
| taos_ch2 | output | 1 | Send-all-ones command, channel 2 |
| taos_ch3 | output | 1 | Send-all-ones command, channel 3 |

## Verification
The checker watches four things on every cycle:
- The commit strobe is never high for two cycles in a row.
- Read data never moves while it is being driven.
- An out-of-range read presents 0.
- Hardware mode never reaches the register port, and host mode keeps the channel commands off.

Other behaviour can only be shown by the bench scenarios, since it depends on data that went into the bank earlier:
- That either bus style lands the right data at the right address.
- That the tied strobe-and-select case works.
- That a select-less strobe, an out-of-range write or a hardware-mode write leaves the registers untouched.

// File: rtl/dualbus_pkg.sv
`timescale 1ns/1ps
package dualbus_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_LATCH = 3'd1,
        ST_ARMED = 3'd2,
        ST_WRITE = 3'd3,
        ST_DRAIN = 3'd4,
        ST_READ  = 3'd5
    } ctrl_state_e;

    // Synchronised control pin bundle order: {ale_as, cs_n, rd_ds_n, wr_rw}
    localparam int CTRL_W = 4;
    localparam logic [CTRL_W-1:0] CTRL_IDLE = 4'b0111;

endpackage

// File: rtl/dualbus_sync.sv
`timescale 1ns/1ps
module dualbus_sync #(
    parameter int               WIDTH   = 1,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                stage_q[i] <= RST_VAL;
            end
        end else begin
            stage_q[0] <= din;
            for (int i = 1; i < STAGES; i++) begin
                stage_q[i] <= stage_q[i-1];
            end
        end
    end

    assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/dualbus_addr_latch.sv
`timescale 1ns/1ps
module dualbus_addr_latch #(
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (load) begin
            addr_q <= addr_in;
        end
    end

endmodule

// File: rtl/dualbus_ctrl.sv
`timescale 1ns/1ps
module dualbus_ctrl
    import dualbus_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        mode_host,
    input  logic        bus_moto,
    input  logic        ale_as_s,
    input  logic        cs_n_s,
    input  logic        rd_ds_n_s,
    input  logic        wr_rw_s,
    output logic        addr_load,
    output logic        wr_en,
    output logic        rd_active
);

    ctrl_state_e st, nxt;

    logic sel;
    logic moto_sel;
    logic rd_req;
    logic wr_req;
    logic rd_released;
    logic wr_released;

    // Request decode, per bus style
    always_comb begin
        sel      = !cs_n_s;
        moto_sel = sel && !ale_as_s;
        if (bus_moto) begin
            rd_req      = moto_sel && !rd_ds_n_s && wr_rw_s;
            wr_req      = moto_sel && !rd_ds_n_s && !wr_rw_s;
            rd_released = rd_ds_n_s;
            wr_released = rd_ds_n_s;
        end else begin
            rd_req      = sel && !rd_ds_n_s;
            wr_req      = sel && !wr_rw_s;
            rd_released = rd_ds_n_s;
            wr_released = wr_rw_s;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= ST_IDLE;
        end else begin
            st <= nxt;
        end
    end

    // Next-state logic
    always_comb begin
        nxt = st;
        if (!mode_host) begin
            nxt = ST_IDLE;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    if (bus_moto) begin
                        if (moto_sel) nxt = ST_ARMED;
                    end else if (ale_as_s) begin
                        nxt = ST_LATCH;
                    end
                end
                ST_LATCH: begin
                    if (!ale_as_s) nxt = ST_ARMED;
                end
                ST_ARMED: begin
                    if (bus_moto) begin
                        if (!moto_sel)   nxt = ST_IDLE;
                        else if (wr_req) nxt = ST_WRITE;
                        else if (rd_req) nxt = ST_READ;
                    end else begin
                        if (ale_as_s)    nxt = ST_LATCH;
                        else if (wr_req) nxt = ST_WRITE;
                        else if (rd_req) nxt = ST_READ;
                    end
                end
                ST_WRITE: begin
                    nxt = ST_DRAIN;
                end
                ST_DRAIN: begin
                    if (bus_moto) begin
                        if (!moto_sel)        nxt = ST_IDLE;
                        else if (wr_released) nxt = ST_ARMED;
                    end else if (!sel || wr_released) begin
                        nxt = ST_IDLE;
                    end
                end
                ST_READ: begin
                    if (bus_moto) begin
                        if (!moto_sel)        nxt = ST_IDLE;
                        else if (rd_released) nxt = ST_ARMED;
                    end else if (!sel || rd_released) begin
                        nxt = ST_IDLE;
                    end
                end
                default: nxt = ST_IDLE;
            endcase
        end
    end

    // Output decode
    always_comb begin
        addr_load = 1'b0;
        wr_en     = 1'b0;
        rd_active = 1'b0;
        unique case (st)
            ST_IDLE:  addr_load = mode_host && bus_moto && moto_sel;
            ST_LATCH: addr_load = ale_as_s;
            ST_WRITE: wr_en     = 1'b1;
            ST_READ:  rd_active = 1'b1;
            ST_ARMED, ST_DRAIN: ;
            default: ;
        endcase
    end

endmodule

// File: rtl/dualbus_regbank.sv
`timescale 1ns/1ps
module dualbus_regbank #(
    parameter int ADDR_W   = 7,
    parameter int DATA_W   = 8,
    parameter int NUM_REGS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
    localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(NUM_REGS);

    logic [DATA_W-1:0] regs [NUM_REGS];
    logic              hit;
    logic [IDX_W-1:0]  idx;

    assign hit = {1'b0, addr} < LIMIT;
    assign idx = addr[IDX_W-1:0];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                regs[g] <= '0;
            end else if (wr_en && hit && (idx == IDX_W'(g))) begin
                regs[g] <= wdata;
            end
        end
    end

    assign rdata = hit ? regs[idx] : '0;

endmodule

// File: rtl/dualbus_regport.sv
`timescale 1ns/1ps
module dualbus_regport
    import dualbus_pkg::*;
#(
    parameter int ADDR_W   = 7,
    parameter int DATA_W   = 8,
    parameter int NUM_REGS = 16,
    parameter int SYNC_N   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_host,
    input  logic              bus_moto,
    input  logic              ale_as,
    input  logic              cs_n,
    input  logic              rd_ds_n,
    input  logic              wr_rw,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_oe,
    output logic              taos_ch2,
    output logic              taos_ch3
);

    localparam int BUS_W = ADDR_W + DATA_W;

    logic [CTRL_W-1:0] ctrl_s;
    logic [BUS_W-1:0]  bus_s;
    logic              ale_as_s, cs_n_s, rd_ds_n_s, wr_rw_s;
    logic [ADDR_W-1:0] addr_s;
    logic [DATA_W-1:0] wdata_s;
    logic              addr_load, wr_en, rd_active;
    logic [ADDR_W-1:0] lat_addr;
    logic [DATA_W-1:0] bank_rdata;

    dualbus_sync #(
        .WIDTH  (CTRL_W),
        .STAGES (SYNC_N),
        .RST_VAL(CTRL_IDLE)
    ) u_sync_ctrl (
        .clk (clk),
        .rst_n(rst_n),
        .din ({ale_as, cs_n, rd_ds_n, wr_rw}),
        .dout(ctrl_s)
    );

    dualbus_sync #(
        .WIDTH  (BUS_W),
        .STAGES (SYNC_N),
        .RST_VAL('0)
    ) u_sync_bus (
        .clk (clk),
        .rst_n(rst_n),
        .din ({addr, wdata}),
        .dout(bus_s)
    );

    assign {ale_as_s, cs_n_s, rd_ds_n_s, wr_rw_s} = ctrl_s;
    assign {addr_s, wdata_s} = bus_s;

    dualbus_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_host(mode_host),
        .bus_moto (bus_moto),
        .ale_as_s (ale_as_s),
        .cs_n_s   (cs_n_s),
        .rd_ds_n_s(rd_ds_n_s),
        .wr_rw_s  (wr_rw_s),
        .addr_load(addr_load),
        .wr_en    (wr_en),
        .rd_active(rd_active)
    );

    dualbus_addr_latch #(
        .ADDR_W(ADDR_W)
    ) u_addr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (addr_load),
        .addr_in(addr_s),
        .addr_q (lat_addr)
    );

    dualbus_regbank #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .NUM_REGS(NUM_REGS)
    ) u_bank (
        .clk  (clk),
        .rst_n(rst_n),
        .wr_en(wr_en),
        .addr (lat_addr),
        .wdata(wdata_s),
        .rdata(bank_rdata)
    );

    // Registered outputs: read data captured once on entry, then held
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata    <= '0;
            rdata_oe <= 1'b0;
            taos_ch2 <= 1'b0;
            taos_ch3 <= 1'b0;
        end else begin
            rdata_oe <= rd_active;
            if (!rd_active) begin
                rdata <= '0;
            end else if (!rdata_oe) begin
                rdata <= bank_rdata;
            end
            taos_ch2 <= !mode_host && ale_as_s;
            taos_ch3 <= !mode_host && cs_n_s;
        end
    end

endmodule

// File: rtl/dualbus_regport_chk.sv
`timescale 1ns/1ps
module dualbus_regport_chk #(
    parameter int ADDR_W   = 7,
    parameter int DATA_W   = 8,
    parameter int NUM_REGS = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mode_host,
    input logic              wr_en,
    input logic [ADDR_W-1:0] lat_addr,
    input logic              rdata_oe,
    input logic [DATA_W-1:0] rdata,
    input logic              taos_ch2,
    input logic              taos_ch3
);

    localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(NUM_REGS);

    a_r6_single_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);

    a_r7_read_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata_oe && $past(rdata_oe)) |-> $stable(rdata));

    a_r8_oob_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rdata_oe) && ({1'b0, $past(lat_addr)} >= LIMIT)) |-> (rdata == '0));

    a_r9_hw_no_access: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_host && $past(!mode_host)) |-> (!wr_en && !rdata_oe));

    a_r10_taos_off_host: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_host && $past(mode_host)) |-> (!taos_ch2 && !taos_ch3));

endmodule

bind dualbus_regport dualbus_regport_chk #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .NUM_REGS(NUM_REGS)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_host(mode_host),
    .wr_en    (wr_en),
    .lat_addr (lat_addr),
    .rdata_oe (rdata_oe),
    .rdata    (rdata),
    .taos_ch2 (taos_ch2),
    .taos_ch3 (taos_ch3)
);

// File: tb/dualbus_regport_tb.sv
`timescale 1ns/1ps
module dualbus_regport_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_host = 1'b1;
    logic       bus_moto = 1'b0;
    logic       ale_as = 1'b0;
    logic       cs_n = 1'b1;
    logic       rd_ds_n = 1'b1;
    logic       wr_rw = 1'b1;
    logic [6:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       rdata_oe;
    logic       taos_ch2;
    logic       taos_ch3;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    dualbus_regport dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_host(mode_host),
        .bus_moto (bus_moto),
        .ale_as   (ale_as),
        .cs_n     (cs_n),
        .rd_ds_n  (rd_ds_n),
        .wr_rw    (wr_rw),
        .addr     (addr),
        .wdata    (wdata),
        .rdata    (rdata),
        .rdata_oe (rdata_oe),
        .taos_ch2 (taos_ch2),
        .taos_ch3 (taos_ch3)
    );

    // Vector: {moto, write, tied, addr[6:0], data[7:0]}; for reads data is the expected value
    localparam int NV = 12;
    localparam logic [17:0] VEC [NV] = '{
        {1'b0, 1'b1, 1'b0, 7'd3,   8'hA5},
        {1'b1, 1'b1, 1'b0, 7'd5,   8'h3C},
        {1'b1, 1'b1, 1'b1, 7'd15,  8'h81},
        {1'b0, 1'b0, 1'b0, 7'd3,   8'hA5},
        {1'b1, 1'b0, 1'b0, 7'd5,   8'h3C},
        {1'b0, 1'b0, 1'b0, 7'd15,  8'h81},
        {1'b0, 1'b1, 1'b0, 7'd100, 8'hFF},
        {1'b1, 1'b0, 1'b0, 7'd100, 8'h00},
        {1'b1, 1'b0, 1'b1, 7'd3,   8'hA5},
        {1'b0, 1'b1, 1'b0, 7'd0,   8'h11},
        {1'b1, 1'b0, 1'b1, 7'd0,   8'h11},
        {1'b0, 1'b0, 1'b0, 7'd5,   8'h3C}
    };

    task automatic wcyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic access(input logic moto, input logic wr, input logic tied,
                          input logic [6:0] a, input logic [7:0] d,
                          input int hold, input logic sel, output logic [7:0] got);
        cs_n = 1'b1;
        ale_as = moto;
        rd_ds_n = 1'b1;
        wr_rw = 1'b1;
        bus_moto = moto;
        wcyc(3);
        addr = a;
        wdata = d;
        got = '0;
        if (!moto) begin
            ale_as = 1'b1;
            wcyc(4);
            ale_as = 1'b0;
            wcyc(3);
            cs_n = !sel;
            wcyc(3);
            if (wr) wr_rw = 1'b0; else rd_ds_n = 1'b0;
            wcyc(hold);
            got = rdata;
            rd_ds_n = 1'b1;
            wr_rw = 1'b1;
            wcyc(4);
            cs_n = 1'b1;
            wcyc(4);
        end else begin
            wr_rw = !wr;
            wcyc(1);
            if (tied) begin
                ale_as = 1'b0;
                cs_n = !sel;
            end else begin
                ale_as = 1'b0;
                wcyc(3);
                cs_n = !sel;
            end
            wcyc(4);
            rd_ds_n = 1'b0;
            wcyc(hold);
            got = rdata;
            rd_ds_n = 1'b1;
            wcyc(4);
            ale_as = 1'b1;
            cs_n = 1'b1;
            wr_rw = 1'b1;
            wcyc(4);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] got;
        string tag;
        wcyc(3);
        rst_n = 1'b1;
        wcyc(3);

        // R1: reset state
        check("R1 rdata", rdata, 8'h00);
        check("R1 rdata_oe", {7'd0, rdata_oe}, 8'h00);
        check("R1 taos", {6'd0, taos_ch2, taos_ch3}, 8'h00);
        access(1'b0, 1'b0, 1'b0, 7'd7, 8'h00, 8, 1'b1, got);
        check("R1 reg7", got, 8'h00);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            access(VEC[i][17], VEC[i][16], VEC[i][15], VEC[i][14:8], VEC[i][7:0], 8, 1'b1, got);
            if (!VEC[i][16]) begin
                if (VEC[i][14:8] >= 7'd16) tag = "R8 oob read";
                else if (VEC[i][15])       tag = "R4 tied read";
                else if (VEC[i][17])       tag = "R3 strobe-style read";
                else                       tag = "R2 latch-style read";
                check(tag, got, VEC[i][7:0]);
            end
        end

        // R5: strobes without chip select
        access(1'b0, 1'b1, 1'b0, 7'd3, 8'h77, 8, 1'b0, got);
        access(1'b1, 1'b1, 1'b0, 7'd5, 8'h66, 8, 1'b0, got);
        access(1'b0, 1'b0, 1'b0, 7'd3, 8'h00, 8, 1'b1, got);
        check("R5 reg3 untouched", got, 8'hA5);
        access(1'b1, 1'b0, 1'b0, 7'd5, 8'h00, 8, 1'b1, got);
        check("R5 reg5 untouched", got, 8'h3C);

        // R6: long write strobe, committed once
        access(1'b0, 1'b1, 1'b0, 7'd9, 8'h5A, 40, 1'b1, got);
        access(1'b1, 1'b0, 1'b1, 7'd9, 8'h00, 8, 1'b1, got);
        check("R6 long write", got, 8'h5A);

        // R7: held read
        bus_moto = 1'b0;
        ale_as = 1'b0;
        wcyc(3);
        addr = 7'd5;
        ale_as = 1'b1;
        wcyc(4);
        ale_as = 1'b0;
        wcyc(3);
        cs_n = 1'b0;
        wcyc(2);
        rd_ds_n = 1'b0;
        wcyc(8);
        check("R7 hold a", rdata, 8'h3C);
        check("R7 oe a", {7'd0, rdata_oe}, 8'h01);
        wcyc(12);
        check("R7 hold b", rdata, 8'h3C);
        check("R7 oe b", {7'd0, rdata_oe}, 8'h01);
        rd_ds_n = 1'b1;
        wcyc(6);
        check("R7 oe released", {7'd0, rdata_oe}, 8'h00);
        check("R7 rdata released", rdata, 8'h00);
        cs_n = 1'b1;
        wcyc(4);

        // R8: out-of-range write did not alias into the bank
        access(1'b0, 1'b0, 1'b0, 7'd4, 8'h00, 8, 1'b1, got);
        check("R8 alias reg4", got, 8'h00);

        // R10: host mode keeps commands off
        bus_moto = 1'b0;
        ale_as = 1'b1;
        cs_n = 1'b1;
        wcyc(5);
        check("R10 taos host", {6'd0, taos_ch2, taos_ch3}, 8'h00);
        ale_as = 1'b0;
        wcyc(5);

        // R9: hardware mode
        mode_host = 1'b0;
        wcyc(3);
        ale_as = 1'b1;
        cs_n = 1'b0;
        wcyc(4);
        check("R9 ch2 on", {6'd0, taos_ch2, taos_ch3}, 8'h02);
        ale_as = 1'b0;
        cs_n = 1'b1;
        wcyc(4);
        check("R9 ch3 on", {6'd0, taos_ch2, taos_ch3}, 8'h01);
        addr = 7'd3;
        wdata = 8'h99;
        ale_as = 1'b1;
        wcyc(4);
        ale_as = 1'b0;
        cs_n = 1'b0;
        wcyc(3);
        wr_rw = 1'b0;
        wcyc(6);
        check("R9 no read drive", {7'd0, rdata_oe}, 8'h00);
        wr_rw = 1'b1;
        cs_n = 1'b1;
        wcyc(3);
        ale_as = 1'b0;
        cs_n = 1'b0;
        wcyc(4);
        check("R9 both off", {6'd0, taos_ch2, taos_ch3}, 8'h00);
        cs_n = 1'b1;
        wcyc(2);
        mode_host = 1'b1;
        wcyc(4);
        access(1'b0, 1'b0, 1'b0, 7'd3, 8'h00, 8, 1'b1, got);
        check("R9 reg3 untouched", got, 8'hA5);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule